// File: doc/BRIEF.md
# Self-Healing Triple-Copy Line Decoder

This block protects a binary-to-one-hot line decoder against single interconnect faults. The decoder is built three times: two working copies produce candidate outputs, and a third copy serves only as the comparison reference. For every output bit, each working copy is XOR-compared with the reference. A two-bit selection code is derived from the two compare results, and a per-bit multiplexer forwards a value that agrees with the reference. Because this is done bit by bit, a single broken line anywhere in the copies, the comparators or the selection codes leaves the delivered word intact.

A fault-injection port makes the healing behaviour observable. It can force one internal line to 0 or 1, or invert it. The corrected word is available both combinationally and as a registered copy. A per-comparator mismatch vector and a summary error flag show where a disagreement was seen.

Top module: `selfHealDecoder`

## Requirements
- R1: With no fault active, `healedNow` equals a one-hot word with bit `sel` set while `en` is 1, and equals all zeros while `en` is 0.
- R2: `healedQ` takes the value `healedNow` had before each rising clock edge. When `rst` is 1 at an edge, `healedQ` becomes zero at that edge.
- R3: A fault on a copy-A output line (`faultLine` 0 to OUT_W-1, bit index = line) does not change `healedNow` in the same cycle. This holds for every fault mode.
- R4: A fault on a copy-B output line (`faultLine` OUT_W to 2·OUT_W-1, bit index = line-OUT_W) does not change `healedNow` in the same cycle. This holds for every fault mode.
- R5: A fault on a comparator output (`faultLine` 2·OUT_W to 3·OUT_W-1 for copy A, 3·OUT_W to 4·OUT_W-1 for copy B) does not change `healedNow`.
- R6: A fault on a per-bit selection code (`faultLine` 4·OUT_W to 5·OUT_W-1) does not change `healedNow`. For a selection fault, stuck-at-0 forces the code to 00, stuck-at-1 forces it to 11, and toggle inverts both code bits. Code 00 picks copy A, 01 picks copy B, and 10 or 11 picks the reference. Before any fault, the code picks copy A if A agrees with the reference, otherwise copy B if B agrees, otherwise the reference.
- R7: `mismatch[i]` is the copy-A comparator output for bit i, and `mismatch[OUT_W+i]` is the copy-B comparator output for bit i, both after any injected fault. `errFlag` is the OR of all `mismatch` bits.
- R8: `faultMode` is encoded as 00 none, 01 stuck-at-0, 10 stuck-at-1 and 11 toggle. When `faultEn` is 0, when the mode is 00, or when `faultLine` is 5·OUT_W or higher, no line is disturbed and `mismatch` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| en | input | 1 | Decoder enable |
| sel | input | SEL_W | Binary select to decode |
| faultEn | input | 1 | Enables the injected fault |
| faultMode | input | 2 | Fault kind: 00 none, 01 stuck-at-0, 10 stuck-at-1, 11 toggle |
| faultLine | input | LINE_W | Index of the internal line to disturb |
| healedNow | output | OUT_W | Corrected decoder word, combinational |
| healedQ | output | OUT_W | Corrected decoder word, registered |
| errFlag | output | 1 | Some comparator reports a mismatch |
| mismatch | output | 2·OUT_W | Per-bit comparator outputs, copy A low half, copy B high half |

## Verification
The bench builds the block with the default SEL_W of 3, which gives 8 output bits, 40 faultable lines and a 6-bit line index. At this size the sweep covers every enable and select value. It also covers every fault mode, both settings of the fault enable, and all 64 line indices, including the 24 indices beyond the last real line. That crosses every single fault with every input word, so each stuck-at or toggle fault is checked at both a 1 bit and a 0 bit of the decoded word. Expected words and mismatch patterns come from shift and index arithmetic in the bench.

// File: rtl/healPkg.sv
package healPkg;

  typedef enum logic [1:0] {
    FM_NONE = 2'b00,
    FM_LOW  = 2'b01,
    FM_HIGH = 2'b10,
    FM_FLIP = 2'b11
  } faultMode_e;

  // strobes from fault control to datapath, at most one set
  typedef struct packed {
    logic forceLow;
    logic forceHigh;
    logic invert;
  } faultStrobe_t;

  localparam logic [1:0] PICK_A   = 2'b00;
  localparam logic [1:0] PICK_B   = 2'b01;
  localparam logic [1:0] PICK_REF = 2'b10;

  function automatic logic injectBit(logic v, logic hit, faultStrobe_t s);
    if (!hit)       return v;
    if (s.forceLow) return 1'b0;
    if (s.forceHigh) return 1'b1;
    if (s.invert)   return ~v;
    return v;
  endfunction

  function automatic logic [1:0] injectCode(logic [1:0] v, logic hit, faultStrobe_t s);
    if (!hit)        return v;
    if (s.forceLow)  return 2'b00;
    if (s.forceHigh) return 2'b11;
    if (s.invert)    return ~v;
    return v;
  endfunction

endpackage

// File: rtl/lineDecoder.sv
module lineDecoder #(
  parameter  int SEL_W = 3,
  localparam int OUT_W = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [OUT_W-1:0] dec
);
  always_comb begin
    dec = '0;
    if (en) dec[sel] = 1'b1;
  end
endmodule

// File: rtl/healFaultCtrl.sv
module healFaultCtrl
  import healPkg::*;
#(
  parameter int LINE_COUNT = 40,
  parameter int LINE_W     = 6
) (
  input  logic                  faultEn,
  input  logic [1:0]            faultMode,
  input  logic [LINE_W-1:0]     faultLine,
  output faultStrobe_t          strobe,
  output logic [LINE_COUNT-1:0] lineHit
);
  logic active;
  assign active = faultEn && (faultMode != FM_NONE);

  assign strobe.forceLow  = active && (faultMode == FM_LOW);
  assign strobe.forceHigh = active && (faultMode == FM_HIGH);
  assign strobe.invert    = active && (faultMode == FM_FLIP);

  for (genvar k = 0; k < LINE_COUNT; k++) begin : g_hit
    assign lineHit[k] = active && (faultLine == LINE_W'(k));
  end

  // R8: only a single line may be disturbed at a time
  always_comb begin
    single_line_chk: assert ($onehot0(lineHit));
  end

  // R8: a hit line always comes with exactly one fault kind
  always_comb begin
    strobe_kind_chk: assert ((lineHit == '0) || ($countones(strobe) == 1));
  end
endmodule

// File: rtl/healDatapath.sv
module healDatapath
  import healPkg::*;
#(
  parameter  int SEL_W      = 3,
  localparam int OUT_W      = 1 << SEL_W,
  localparam int LINE_COUNT = 5 * OUT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [SEL_W-1:0]      sel,
  input  faultStrobe_t          strobe,
  input  logic [LINE_COUNT-1:0] lineHit,
  output logic [OUT_W-1:0]      healedNow,
  output logic [OUT_W-1:0]      healedQ,
  output logic [2*OUT_W-1:0]    mismatch
);
  logic [OUT_W-1:0] decA, decB, decRef;
  logic [OUT_W-1:0] wireA, wireB, cmpA, cmpB;

  lineDecoder #(.SEL_W(SEL_W)) copyA_i   (.en(en), .sel(sel), .dec(decA));
  lineDecoder #(.SEL_W(SEL_W)) copyB_i   (.en(en), .sel(sel), .dec(decB));
  lineDecoder #(.SEL_W(SEL_W)) copyRef_i (.en(en), .sel(sel), .dec(decRef));

  for (genvar i = 0; i < OUT_W; i++) begin : g_bit
    logic [1:0] pickRaw, pickCode;

    assign wireA[i] = injectBit(decA[i], lineHit[i], strobe);
    assign wireB[i] = injectBit(decB[i], lineHit[OUT_W + i], strobe);
    assign cmpA[i]  = injectBit(wireA[i] ^ decRef[i], lineHit[2*OUT_W + i], strobe);
    assign cmpB[i]  = injectBit(wireB[i] ^ decRef[i], lineHit[3*OUT_W + i], strobe);

    // priority: copy A, then copy B, then reference
    assign pickRaw  = !cmpA[i] ? PICK_A : (!cmpB[i] ? PICK_B : PICK_REF);
    assign pickCode = injectCode(pickRaw, lineHit[4*OUT_W + i], strobe);

    assign healedNow[i] = (pickCode == PICK_A) ? wireA[i] :
                          (pickCode == PICK_B) ? wireB[i] : decRef[i];
  end

  assign mismatch = {cmpB, cmpA};

  always_ff @(posedge clk) begin
    if (rst) healedQ <= '0;
    else     healedQ <= healedNow;
  end

  // R3 R4 R5 R6: mux output always agrees with the untouched reference copy
  healed_ref_chk: assert property (@(posedge clk) disable iff (rst)
    healedNow == decRef);

  // R1
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> healedNow == '0);

  // R1
  onehot_word_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(healedNow));

  // R2
  register_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> healedQ == $past(healedNow));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> healedQ == '0);

  // R8
  quiet_compare_chk: assert property (@(posedge clk) disable iff (rst)
    (lineHit == '0) |-> mismatch == '0);
endmodule

// File: rtl/selfHealDecoder.sv
module selfHealDecoder
  import healPkg::*;
#(
  parameter  int SEL_W      = 3,
  localparam int OUT_W      = 1 << SEL_W,
  localparam int LINE_COUNT = 5 * OUT_W,
  localparam int LINE_W     = $clog2(LINE_COUNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  input  logic               faultEn,
  input  logic [1:0]         faultMode,
  input  logic [LINE_W-1:0]  faultLine,
  output logic [OUT_W-1:0]   healedNow,
  output logic [OUT_W-1:0]   healedQ,
  output logic               errFlag,
  output logic [2*OUT_W-1:0] mismatch
);
  faultStrobe_t          strobe;
  logic [LINE_COUNT-1:0] lineHit;

  healFaultCtrl #(.LINE_COUNT(LINE_COUNT), .LINE_W(LINE_W)) ctrl_i (
    .faultEn(faultEn), .faultMode(faultMode), .faultLine(faultLine),
    .strobe(strobe), .lineHit(lineHit)
  );

  healDatapath #(.SEL_W(SEL_W)) data_i (
    .clk(clk), .rst(rst), .en(en), .sel(sel),
    .strobe(strobe), .lineHit(lineHit),
    .healedNow(healedNow), .healedQ(healedQ), .mismatch(mismatch)
  );

  assign errFlag = |mismatch;

  // R7 R8
  fault_off_chk: assert property (@(posedge clk) disable iff (rst)
    !faultEn |-> !errFlag);
endmodule

// File: tb/selfHealDecoder_tb_top.sv
`timescale 1ns/1ps
module selfHealDecoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [2:0] sel = '0;
  logic       faultEn = 1'b0;
  logic [1:0] faultMode = 2'b00;
  logic [5:0] faultLine = '0;
  logic [7:0]  healedNow, healedQ;
  logic        errFlag;
  logic [15:0] mismatch;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  selfHealDecoder dut_i (
    .clk(clk), .rst(rst), .en(en), .sel(sel),
    .faultEn(faultEn), .faultMode(faultMode), .faultLine(faultLine),
    .healedNow(healedNow), .healedQ(healedQ),
    .errFlag(errFlag), .mismatch(mismatch)
  );

  task automatic checkVal(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (en=%0d sel=%0d fe=%0d mode=%0d line=%0d)",
               tag, act, exp, en, sel, faultEn, faultMode, faultLine);
    end
  endtask

  function automatic logic [7:0] expDec(logic e, logic [2:0] s);
    return e ? (8'h01 << s) : 8'h00;
  endfunction

  function automatic logic faultOf(logic v, logic [1:0] m);
    case (m)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~v;
      default: return v;
    endcase
  endfunction

  task automatic runReset();
    @(negedge clk);
    rst = 1'b1; en = 1'b1; sel = 3'd5;
    @(posedge clk); #1;
    checkVal("R2 reset clears", {8'h00, healedQ}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    runReset();
    for (int e = 0; e < 2; e++) begin
      for (int s = 0; s < 8; s++) begin
        for (int fe = 0; fe < 2; fe++) begin
          for (int m = 0; m < 4; m++) begin
            for (int ln = 0; ln < 64; ln++) begin
              logic [7:0]  word;
              logic [15:0] expMis;
              logic        live;
              string       tag;
              @(negedge clk);
              en = e[0]; sel = s[2:0]; faultEn = fe[0];
              faultMode = m[1:0]; faultLine = ln[5:0];
              word   = expDec(e[0], s[2:0]);
              expMis = '0;
              live   = (fe == 1) && (m != 0) && (ln < 40);
              if (!live) tag = (fe == 0 || m == 0) ? "R1" : "R8";
              else if (ln < 8) begin
                tag = "R3";
                expMis[ln % 8] = faultOf(word[ln % 8], m[1:0]) != word[ln % 8];
              end else if (ln < 16) begin
                tag = "R4";
                expMis[8 + ln % 8] = faultOf(word[ln % 8], m[1:0]) != word[ln % 8];
              end else if (ln < 24) begin
                tag = "R5";
                expMis[ln % 8] = faultOf(1'b0, m[1:0]);
              end else if (ln < 32) begin
                tag = "R5";
                expMis[8 + ln % 8] = faultOf(1'b0, m[1:0]);
              end else tag = "R6";
              #1;
              checkVal({tag, " healed word"}, {8'h00, healedNow}, {8'h00, word});
              checkVal("R7 mismatch vector", mismatch, expMis);
              checkVal("R7 error flag", {15'h0, errFlag}, {15'h0, |expMis});
              @(posedge clk); #1;
              checkVal("R2 registered word", {8'h00, healedQ}, {8'h00, word});
            end
          end
        end
      end
    end
    runReset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule